// File: doc/BRIEF.md
# System Clock Source Switch Controller

This controller chooses which of three clock sources drives the system clock: the on-chip RC oscillator, an external crystal oscillator, or the PLL output. Software writes a 2-bit selection code. The controller moves the clock mux to that source only when the source reports ready. Until then the previous source stays in use. A separate 2-bit status output always shows the source that actually drives the clock.

Hardware can override software and fall back to the on-chip oscillator. It does so when the chip leaves a low-power stop or standby state. It also does so when the external oscillator fails while it clocks the system, either directly or as the reference of the PLL that is in use. A fallback rewrites the software-visible selection field to the on-chip code in the same cycle that the mux moves. The glitch-free mux cells that follow are modelled only by their one-hot select.

Top module: `sysclk_switch_ctrl`

## Requirements
- R1: After reset, the selection field reads 00, the status reads 00 and the mux select is 001.
- R2: A software write of code 00 (on-chip RC), 01 (external oscillator) or 10 (PLL) shows in the selection field one clock after the write cycle.
- R3: A software write of code 11 is ignored, and the selection field keeps its previous value.
- R4: When the selection field differs from the active source, the active source changes to the selected one on the first clock edge at which that source's ready input is high. Until then the status holds the old code.
- R5: The status uses the codes 00, 01 and 10 and never reads 11. The mux select is one-hot: bit 0 selects the on-chip RC, bit 1 the external oscillator and bit 2 the PLL. The bit that is set matches the status code.
- R6: A low-power exit pulse sets both the selection field and the status to 00 at the next clock edge, whatever the state of the ready inputs.
- R7: An external-oscillator failure while the external oscillator is the active source sets the selection field and the status to 00 at the next clock edge.
- R8: An external-oscillator failure while the PLL is active and the PLL reference input is 1 (external reference) sets the selection field and the status to 00 at the next clock edge.
- R9: An external-oscillator failure has no effect when the on-chip RC is active, or when the PLL is active with the PLL reference input at 0 (on-chip reference).
- R10: A hardware fallback takes precedence over a software write in the same cycle. The selection field becomes 00, not the written code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr_en | input | 1 | Software write strobe for the selection field |
| sw_wr_code | input | 2 | Code written to the selection field |
| src_ready | input | 3 | Ready flags: bit 0 on-chip RC, bit 1 external, bit 2 PLL |
| pll_ref_ext | input | 1 | 1 when the PLL is referenced to the external oscillator |
| ext_fail | input | 1 | External-oscillator failure detect |
| lp_exit | input | 1 | One-cycle pulse on exit from stop or standby |
| sel_field | output | 2 | Software-visible selection field |
| src_status | output | 2 | Code of the source that actually drives the clock |
| mux_sel | output | 3 | One-hot select for the glitch-free clock mux |

## Verification
Switches are tried with the target ready, with the target not yet ready and then becoming ready, and with a fallback arriving while a switch is still pending. These cases separate the software field from the active source and confirm the two-step timing. Failure pulses are applied with each source active and with both PLL references, so a design that falls back on any failure, or only on direct use, shows a mismatch. The invalid code and writes made in the same cycle as a fallback confirm that the field holds its value and that hardware has priority.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

   localparam int SRC_COUNT = 3;
   localparam int SRC_CODE_W = 2;

   typedef enum logic [SRC_CODE_W-1:0] {
      SRC_RC  = 2'd0,
      SRC_EXT = 2'd1,
      SRC_PLL = 2'd2
   } src_e;

endpackage

// File: rtl/sclk_ready_sync.sv
module sclk_ready_sync #(
   parameter int NUM_SRC = 3,
   parameter int STAGES  = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] ready_in,
   output logic [NUM_SRC-1:0] ready_out
);

   initial begin
      if (STAGES < 0 || STAGES > 4)
         $error("sclk_ready_sync: STAGES must lie in 0..4");
   end

   generate
      if (STAGES == 0) begin : g_direct
         assign ready_out = ready_in;
      end else begin : g_chain
         logic [NUM_SRC-1:0] stage_q [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
               if (!rst_n)
                  stage_q[s] <= '0;
               else if (s == 0)
                  stage_q[s] <= ready_in;
               else
                  stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
         end
         assign ready_out = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sclk_sel_field.sv
module sclk_sel_field #(
   parameter int NUM_SRC = 3,
   parameter int CODE_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              force_rc,
   input  logic              wr_en,
   input  logic [CODE_W-1:0] wr_code,
   output logic [CODE_W-1:0] sel_q
);

   logic code_ok;

   // Codes at or above NUM_SRC are not allowed and are dropped.
   assign code_ok = (int'(wr_code) < NUM_SRC);

   always_ff @(posedge clk) begin
      if (!rst_n)
         sel_q <= '0;
      else if (force_rc)
         sel_q <= '0;
      else if (wr_en && code_ok)
         sel_q <= wr_code;
   end

endmodule

// File: rtl/sclk_switch_core.sv
module sclk_switch_core #(
   parameter int NUM_SRC = 3,
   parameter int CODE_W  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CODE_W-1:0]  target,
   input  logic [NUM_SRC-1:0] ready,
   input  logic               pll_ref_ext,
   input  logic               ext_fail,
   input  logic               lp_exit,
   output logic               force_rc,
   output logic [CODE_W-1:0]  active_q
);

   import sclk_pkg::*;

   logic target_ready;
   logic ext_in_path;

   always_comb begin
      target_ready = 1'b0;
      for (int i = 0; i < NUM_SRC; i++)
         if (target == CODE_W'(i))
            target_ready = ready[i];
   end

   // The external oscillator feeds the clock directly, or through the PLL.
   assign ext_in_path = (active_q == SRC_EXT) ||
                        ((active_q == SRC_PLL) && pll_ref_ext);

   assign force_rc = lp_exit || (ext_fail && ext_in_path);

   always_ff @(posedge clk) begin
      if (!rst_n)
         active_q <= SRC_RC;
      else if (force_rc)
         active_q <= SRC_RC;
      else if ((target != active_q) && target_ready)
         active_q <= target;
   end

endmodule

// File: rtl/sysclk_switch_ctrl.sv
module sysclk_switch_ctrl #(
   parameter int NUM_SRC     = 3,
   parameter int SYNC_STAGES = 0,
   localparam int CODE_W     = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sw_wr_en,
   input  logic [CODE_W-1:0]  sw_wr_code,
   input  logic [NUM_SRC-1:0] src_ready,
   input  logic               pll_ref_ext,
   input  logic               ext_fail,
   input  logic               lp_exit,
   output logic [CODE_W-1:0]  sel_field,
   output logic [CODE_W-1:0]  src_status,
   output logic [NUM_SRC-1:0] mux_sel
);

   initial begin
      if (NUM_SRC != sclk_pkg::SRC_COUNT)
         $error("sysclk_switch_ctrl: NUM_SRC must equal the package source count");
      if (CODE_W != sclk_pkg::SRC_CODE_W)
         $error("sysclk_switch_ctrl: code width mismatch with package");
   end

   logic [NUM_SRC-1:0] ready_s;
   logic               force_rc;
   logic [CODE_W-1:0]  active;

   sclk_ready_sync #(
      .NUM_SRC (NUM_SRC),
      .STAGES  (SYNC_STAGES)
   ) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .ready_in  (src_ready),
      .ready_out (ready_s)
   );

   sclk_sel_field #(
      .NUM_SRC (NUM_SRC),
      .CODE_W  (CODE_W)
   ) u_field (
      .clk      (clk),
      .rst_n    (rst_n),
      .force_rc (force_rc),
      .wr_en    (sw_wr_en),
      .wr_code  (sw_wr_code),
      .sel_q    (sel_field)
   );

   sclk_switch_core #(
      .NUM_SRC (NUM_SRC),
      .CODE_W  (CODE_W)
   ) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .target      (sel_field),
      .ready       (ready_s),
      .pll_ref_ext (pll_ref_ext),
      .ext_fail    (ext_fail),
      .lp_exit     (lp_exit),
      .force_rc    (force_rc),
      .active_q    (active)
   );

   assign src_status = active;

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_onehot
         assign mux_sel[i] = (active == CODE_W'(i));
      end
   endgenerate

endmodule

// File: rtl/sysclk_switch_ctrl_chk.sv
module sysclk_switch_ctrl_chk #(
   parameter int NUM_SRC = 3,
   parameter int CODE_W  = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               sw_wr_en,
   input logic [CODE_W-1:0]  sw_wr_code,
   input logic [NUM_SRC-1:0] src_ready,
   input logic               pll_ref_ext,
   input logic               ext_fail,
   input logic               lp_exit,
   input logic [CODE_W-1:0]  sel_field,
   input logic [CODE_W-1:0]  src_status,
   input logic [NUM_SRC-1:0] mux_sel
);

   p_reset_state_r1: assert property (@(posedge clk)
      !rst_n |=> (sel_field == '0) && (src_status == '0));

   p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(mux_sel) == 1) && (int'(src_status) < NUM_SRC));

   p_no_bad_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr_en && int'(sw_wr_code) >= NUM_SRC && !lp_exit && !ext_fail)
      |=> (sel_field == $past(sel_field)));

   p_wait_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((sel_field == CODE_W'(1)) && (src_status != CODE_W'(1)) && !src_ready[1]
       && !lp_exit && !ext_fail)
      |=> (src_status == $past(src_status)));

   p_lp_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lp_exit |=> (sel_field == '0) && (src_status == '0));

   p_ext_fail_direct_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_fail && src_status == CODE_W'(1)) |=> (src_status == '0) && (sel_field == '0));

   p_ext_fail_pll_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_fail && pll_ref_ext && src_status == CODE_W'(2))
      |=> (src_status == '0) && (sel_field == '0));

   p_fail_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_fail && !lp_exit && src_status == CODE_W'(2) && !pll_ref_ext)
      |=> (src_status == CODE_W'(2)));

endmodule

bind sysclk_switch_ctrl sysclk_switch_ctrl_chk #(
   .NUM_SRC (NUM_SRC),
   .CODE_W  (CODE_W)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sw_wr_en    (sw_wr_en),
   .sw_wr_code  (sw_wr_code),
   .src_ready   (src_ready),
   .pll_ref_ext (pll_ref_ext),
   .ext_fail    (ext_fail),
   .lp_exit     (lp_exit),
   .sel_field   (sel_field),
   .src_status  (src_status),
   .mux_sel     (mux_sel)
);

// File: tb/test_sysclk_switch_ctrl.sv
`timescale 1ns/1ps
module test_sysclk_switch_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sw_wr_en = 1'b0;
   logic [1:0] sw_wr_code = 2'd0;
   logic [2:0] src_ready = 3'b111;
   logic       pll_ref_ext = 1'b0;
   logic       ext_fail = 1'b0;
   logic       lp_exit = 1'b0;
   logic [1:0] sel_field;
   logic [1:0] src_status;
   logic [2:0] mux_sel;

   int n_checks = 0;
   int n_fail = 0;

   typedef struct {
      logic [1:0] fld;
      logic [1:0] stat;
      string      tag;
   } exp_t;

   exp_t sb_q[$];

   // bench model state, derived from the requirements
   logic [1:0] m_fld = 2'd0;
   logic [1:0] m_act = 2'd0;

   always #4 clk = ~clk;

   sysclk_switch_ctrl i_sysclk_switch_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .sw_wr_en    (sw_wr_en),
      .sw_wr_code  (sw_wr_code),
      .src_ready   (src_ready),
      .pll_ref_ext (pll_ref_ext),
      .ext_fail    (ext_fail),
      .lp_exit     (lp_exit),
      .sel_field   (sel_field),
      .src_status  (src_status),
      .mux_sel     (mux_sel)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [3:0] act, input logic [3:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // driver: applies one cycle of stimulus and queues the expected result
   task automatic step(input bit wr, input logic [1:0] code, input logic [2:0] rdy,
                       input bit pref, input bit fail, input bit lp, input string tag);
      exp_t e;
      bit   frc;
      @(negedge clk);
      sw_wr_en = wr; sw_wr_code = code; src_ready = rdy;
      pll_ref_ext = pref; ext_fail = fail; lp_exit = lp;
      frc = lp || (fail && (m_act == 2'd1 || (m_act == 2'd2 && pref)));
      if (frc) begin
         m_fld = 2'd0; m_act = 2'd0;
      end else begin
         if (m_fld != m_act && rdy[m_fld]) m_act = m_fld;
         if (wr && code != 2'd3) m_fld = code;
      end
      e.fld = m_fld; e.stat = m_act; e.tag = tag;
      sb_q.push_back(e);
   endtask

   // monitor: compares outputs just after each edge that has a queued item
   always begin
      exp_t e;
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
         e = sb_q.pop_front();
         check(sel_field == e.fld && src_status == e.stat && mux_sel == (3'b001 << e.stat),
               e.tag, "field/status/mux",
               {sel_field, src_status}, {e.fld, e.stat});
      end
   end

   initial begin
      #(8 * 100000);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R1 reset state
      check(sel_field == 2'd0 && src_status == 2'd0 && mux_sel == 3'b001, "R1",
            "reset", {sel_field, src_status}, 4'h0);
      @(negedge clk);
      rst_n = 1'b1;

      step(1, 2'd1, 3'b111, 0, 0, 0, "R2 write ext");
      step(0, 2'd0, 3'b111, 0, 0, 0, "R4 switch to ready ext");
      step(1, 2'd3, 3'b111, 0, 0, 0, "R3 code 11 ignored");
      step(1, 2'd2, 3'b011, 0, 0, 0, "R2 write pll");
      step(0, 2'd0, 3'b011, 0, 0, 0, "R4 pll not ready");
      step(0, 2'd0, 3'b011, 0, 0, 0, "R4 pll still not ready");
      step(0, 2'd0, 3'b111, 0, 0, 0, "R5 pll ready, status 10");
      step(0, 2'd0, 3'b111, 0, 1, 0, "R9 fail, pll on rc ref");
      step(0, 2'd0, 3'b111, 1, 1, 0, "R8 fail, pll on ext ref");
      step(0, 2'd0, 3'b111, 0, 0, 0, "R8 stays on rc");
      step(1, 2'd1, 3'b111, 0, 0, 0, "R2 write ext again");
      step(0, 2'd0, 3'b111, 0, 0, 0, "R4 ext active");
      step(0, 2'd0, 3'b111, 0, 1, 0, "R7 fail, ext direct");
      step(1, 2'd2, 3'b111, 0, 0, 0, "R2 write pll again");
      step(0, 2'd0, 3'b111, 0, 0, 0, "R5 pll active");
      step(1, 2'd1, 3'b111, 0, 0, 1, "R10 lp exit beats write");
      step(0, 2'd0, 3'b111, 1, 1, 0, "R9 fail, rc active");
      step(1, 2'd1, 3'b101, 0, 0, 0, "R2 write ext, not ready");
      step(0, 2'd0, 3'b101, 0, 0, 0, "R4 ext pending");
      step(0, 2'd0, 3'b101, 0, 0, 1, "R6 lp exit cancels pending");
      step(0, 2'd0, 3'b111, 0, 0, 0, "R6 rc kept after exit");
      step(1, 2'd1, 3'b111, 0, 0, 0, "R2 write ext third");
      step(0, 2'd0, 3'b111, 0, 0, 0, "R4 ext active third");
      step(1, 2'd2, 3'b111, 0, 1, 0, "R10 fail beats write");
      step(1, 2'd3, 3'b111, 0, 0, 0, "R3 code 11 on rc");
      step(0, 2'd0, 3'b111, 0, 0, 0, "R3 field unchanged");

      repeat (3) @(posedge clk);
      #3;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule